// File: doc/BRIEF.md
# Attribute Index Divider

This block converts the linear index of a dispatched thread into the element index used to fetch one vertex attribute. Each request carries the index together with the attribute's own addressing constants: a two-bit mode, a five-bit shift, a three-bit odd-factor/flag field and a 32-bit multiplier word. The block returns a single 32-bit element index. Four modes are supported. Mode 0 passes the index through unchanged. Mode 1 reduces it modulo an odd number times a power of two. Mode 2 divides it by a power of two. Mode 3 divides it by an arbitrary constant through a fixed-exponent reciprocal multiply.

Requests enter and results leave on valid/ready streams. A request transfers on a rising edge where `in_valid` and `in_ready` are both high, and a result transfers on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result and `out_valid` hold. The pipeline has two stages. The first registers one shared 65-bit product, and the second applies the correction, the shifts and the remainder. When `out_ready` stays high, a new request is accepted on every cycle. The arbitrary-divisor constants are prepared outside the block: the shift is floor(log2 d), the multiplier is ceil(2^(shift+32)/d), and the round-down variant (multiplier minus one, flag 1) is used when 2^(shift+32) mod d is at most 2^shift.

Top module: `attr_idx_divider`

## Requirements
- R1: With `in_mode` = 0, `out_index` equals `in_index`.
- R2: With `in_mode` = 1, `out_index` = `in_index` mod ((2·`in_xflags`+1)·2^`in_shift`), for every `in_xflags` value 0..7 and every shift 0..31.
- R3: With `in_mode` = 2, `out_index` = `in_index` >> `in_shift`.
- R4: With `in_mode` = 3, the effective multiplier is `in_mult` with bit 31 forced to 1. The result is the high 32 bits of the 64-bit product of `in_index` and that multiplier, shifted right by `in_shift`. When `in_xflags` is not 1, no correction is applied.
- R5: With `in_mode` = 3 and `in_xflags` = 1, the effective multiplier is added to the product before the high half is taken, which is exact even for `in_index` = 0xFFFFFFFF. With constants derived by the rule above and bit 31 stored as 0, the result equals floor(`in_index`/d) for every d from 2 to 65536.
- R6: In an empty pipeline, a request accepted on edge k gives `out_valid` high after edge k+1.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_index` stay unchanged. Results leave in request order, with none lost or duplicated.
- R8: Whenever `out_ready` is high, or `out_valid` is low, `in_ready` is high, so the block sustains one request per cycle.
- R9: While `rst_n` is low and after its release, `out_valid` is low, and any requests in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_index | input | 32 | Linear thread index |
| in_mode | input | 2 | 0 pass, 1 modulo, 2 shift-divide, 3 magic divide |
| in_shift | input | 5 | Power-of-two exponent / post-shift |
| in_xflags | input | 3 | Odd factor selector (mode 1) or round-down flag (mode 3) |
| in_mult | input | 32 | Reciprocal multiplier, bit 31 implied set |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_index | output | 32 | Attribute element index |

## Verification
A corrupted product or stage register gives a wrong `out_index` on the very transfer that carries it, exactly two edges after acceptance in an idle pipeline. An error in the stage-valid logic shows sooner: a held result changes under back-pressure on the next edge, or a result is dropped or repeated, which shows as an order mismatch at the following transfer. A missing implicit multiplier bit or round-down term shows only in mode 3, and often only as an off-by-one result at large indices. For that reason the random exact-division sweep includes the all-ones index.

// File: rtl/attr_div_pkg.sv
package attr_div_pkg;
  localparam int IDX_W   = 32;
  localparam int SHIFT_W = 5;
  localparam int XF_W    = 3;
  localparam int ODD_N   = 1 << XF_W;
  localparam int PROD_W  = 2 * IDX_W + 1;
  localparam int LG_W    = $clog2(XF_W + 2);

  typedef enum logic [1:0] {
    AM_LINEAR = 2'd0,
    AM_WRAP   = 2'd1,
    AM_SHR    = 2'd2,
    AM_MAGIC  = 2'd3
  } attr_mode_e;

  typedef struct packed {
    logic [PROD_W-1:0]  prod;
    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   eff;
    attr_mode_e         mode;
    logic [SHIFT_W-1:0] sh;
    logic [XF_W-1:0]    xf;
    logic [LG_W-1:0]    lg;
  } s1_t;

  // ceil(log2) of the odd factor 2x+1
  function automatic logic [LG_W-1:0] odd_lg(input int unsigned x);
    return LG_W'($clog2(2 * x + 1));
  endfunction

  // Reciprocal of 2x+1 scaled by 2^(IDX_W+lg), rounded up: exact for all IDX_W-bit dividends
  function automatic logic [IDX_W:0] odd_recip(input int unsigned x);
    longint unsigned d, num;
    d   = 64'(2 * x + 1);
    num = 64'd1 << (IDX_W + $clog2(2 * x + 1));
    return (IDX_W + 1)'((num + d - 64'd1) / d);
  endfunction
endpackage

// File: rtl/attr_div_mul.sv
module attr_div_mul
  import attr_div_pkg::*;
(
  input  logic               clk,
  input  logic               ld,
  input  logic [IDX_W-1:0]   idx,
  input  logic [1:0]         mode,
  input  logic [SHIFT_W-1:0] sh,
  input  logic [XF_W-1:0]    xf,
  input  logic [IDX_W-1:0]   mult,
  output s1_t                q
);
  localparam logic [IDX_W-1:0] TOP_BIT = {1'b1, {(IDX_W-1){1'b0}}};

  logic [IDX_W:0]    recip_tab [ODD_N];
  logic [LG_W-1:0]   lg_tab    [ODD_N];

  for (genvar g = 0; g < ODD_N; g++) begin : g_odd
    assign recip_tab[g] = odd_recip(g);
    assign lg_tab[g]    = odd_lg(g);
  end

  attr_mode_e         m_e;
  logic [IDX_W-1:0]   eff;
  logic [IDX_W-1:0]   opa;
  logic [IDX_W:0]     opb;
  s1_t                nxt;

  assign m_e = attr_mode_e'(mode);
  assign eff = mult | TOP_BIT;

  always_comb begin
    unique case (m_e)
      AM_WRAP: begin
        opa = idx >> sh;
        opb = recip_tab[xf];
      end
      AM_MAGIC: begin
        opa = idx;
        opb = {1'b0, eff};
      end
      default: begin
        opa = idx;
        opb = '0;
      end
    endcase
  end

  always_comb begin
    nxt.prod = PROD_W'(opa) * PROD_W'(opb);
    nxt.idx  = idx;
    nxt.eff  = eff;
    nxt.mode = m_e;
    nxt.sh   = sh;
    nxt.xf   = xf;
    nxt.lg   = lg_tab[xf];
  end

  always_ff @(posedge clk) begin
    if (ld) q <= nxt;
  end
endmodule

// File: rtl/attr_div_fin.sv
module attr_div_fin
  import attr_div_pkg::*;
(
  input  logic             clk,
  input  logic             ld,
  input  s1_t              s,
  output logic [IDX_W-1:0] res
);
  localparam int DW = 2 * IDX_W;

  logic [DW-1:0]    corr;
  logic [IDX_W-1:0] hi;
  logic [IDX_W-1:0] quo;
  logic [XF_W:0]    odd;
  logic [IDX_W-1:0] wrap_res;
  logic [IDX_W-1:0] nxt;

  // Round-down: one extra multiplier added equals multiplying by index+1
  assign corr = (s.xf == XF_W'(1)) ? DW'(s.eff) : '0;
  assign hi   = IDX_W'((s.prod[DW-1:0] + corr) >> IDX_W);

  // Quotient by odd factor of the pre-shifted index
  assign quo  = IDX_W'(s.prod >> (IDX_W + int'(s.lg)));
  assign odd  = {s.xf, 1'b1};
  assign wrap_res = s.idx - IDX_W'((DW'(quo) * DW'(odd)) << s.sh);

  always_comb begin
    unique case (s.mode)
      AM_LINEAR: nxt = s.idx;
      AM_WRAP:   nxt = wrap_res;
      AM_SHR:    nxt = s.idx >> s.sh;
      default:   nxt = hi >> s.sh;
    endcase
  end

  always_ff @(posedge clk) begin
    if (ld) res <= nxt;
  end
endmodule

// File: rtl/attr_idx_divider.sv
module attr_idx_divider
  import attr_div_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [IDX_W-1:0]   in_index,
  input  logic [1:0]         in_mode,
  input  logic [SHIFT_W-1:0] in_shift,
  input  logic [XF_W-1:0]    in_xflags,
  input  logic [IDX_W-1:0]   in_mult,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [IDX_W-1:0]   out_index
);
  logic s1_v, s2_v;
  logic s2_take;
  s1_t  s1_q;

  assign s2_take   = !s2_v || out_ready;
  assign in_ready  = !s1_v || s2_take;
  assign out_valid = s2_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      if (in_ready) s1_v <= in_valid;
      if (s2_take)  s2_v <= s1_v;
    end
  end

  attr_div_mul u_mul (
    .clk  (clk),
    .ld   (in_valid && in_ready),
    .idx  (in_index),
    .mode (in_mode),
    .sh   (in_shift),
    .xf   (in_xflags),
    .mult (in_mult),
    .q    (s1_q)
  );

  attr_div_fin u_fin (
    .clk (clk),
    .ld  (s1_v && s2_take),
    .s   (s1_q),
    .res (out_index)
  );
endmodule

// File: rtl/attr_div_chk.sv
module attr_div_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  in_mode,
  input logic [31:0] in_index,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_index
);
  logic       acc, dlv;
  logic [2:0] inflight;

  assign acc = in_valid && in_ready;
  assign dlv = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + 3'(acc) - 3'(dlv);
  end

  p_linear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mode == 2'd0 && inflight == 3'd0) |=> ##1 (out_index == $past(in_index, 2)));

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && inflight == 3'd0) |=> ##1 out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_index)));

  p_known_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_index));

  p_flow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready || !out_valid) |-> in_ready);

  p_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 3'd2);

  p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == 3'd0) |-> !out_valid);
endmodule

bind attr_idx_divider attr_div_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_mode   (in_mode),
  .in_index  (in_index),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_index (out_index)
);

// File: tb/tb_attr_idx_divider.sv
`timescale 1ns/1ps
module tb_attr_idx_divider;
  typedef struct packed {
    logic [1:0]  mode;
    logic [4:0]  sh;
    logic [2:0]  xf;
    logic [31:0] mult;
    logic [31:0] idx;
  } vec_t;

  localparam int NTAB = 16;
  localparam vec_t TAB [NTAB] = '{
    '{2'd0, 5'd0,  3'd0, 32'd0,          32'h12345678},
    '{2'd0, 5'd7,  3'd5, 32'hFFFFFFFF,   32'hFFFFFFFF},
    '{2'd1, 5'd3,  3'd4, 32'd0,          32'd70},
    '{2'd1, 5'd3,  3'd4, 32'd0,          32'd150},
    '{2'd1, 5'd0,  3'd1, 32'd0,          32'hFFFFFFFF},
    '{2'd1, 5'd2,  3'd3, 32'd0,          32'd1000},
    '{2'd1, 5'd31, 3'd0, 32'd0,          32'hFFFFFFFF},
    '{2'd1, 5'd4,  3'd7, 32'd0,          32'd12345},
    '{2'd2, 5'd0,  3'd0, 32'd0,          32'd77},
    '{2'd2, 5'd31, 3'd0, 32'd0,          32'h80000000},
    '{2'd2, 5'd5,  3'd0, 32'd0,          32'hDEADBEEF},
    '{2'd3, 5'd1,  3'd1, 32'h2AAAAAAA,   32'd100},
    '{2'd3, 5'd1,  3'd1, 32'h2AAAAAAA,   32'hFFFFFFFF},
    '{2'd3, 5'd2,  3'd1, 32'h12492492,   32'hFFFFFFFF},
    '{2'd3, 5'd3,  3'd0, 32'd976128931,  32'd99},
    '{2'd3, 5'd3,  3'd2, 32'd976128931,  32'hFFFFFFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_index = '0;
  logic [1:0]  in_mode = '0;
  logic [4:0]  in_shift = '0;
  logic [2:0]  in_xflags = '0;
  logic [31:0] in_mult = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_index;

  int n_chk = 0;
  int n_err = 0;

  vec_t        sv [256];
  logic [31:0] se [256];
  string       st [256];

  always #4 clk = ~clk;

  attr_idx_divider dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_index(in_index), .in_mode(in_mode), .in_shift(in_shift),
    .in_xflags(in_xflags), .in_mult(in_mult),
    .out_valid(out_valid), .out_ready(out_ready), .out_index(out_index)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_out(input vec_t v);
    longint unsigned i, md, eff, p;
    i = 64'(v.idx);
    case (v.mode)
      2'd0: return v.idx;
      2'd1: begin
        md = 64'(2 * v.xf + 1) << v.sh;
        return 32'(i % md);
      end
      2'd2: return v.idx >> v.sh;
      default: begin
        eff = 64'(v.mult | 32'h80000000);
        p = i * eff;
        if (v.xf == 3'd1) p = p + eff;
        return 32'(p >> 32) >> v.sh;
      end
    endcase
  endfunction

  function automatic string tag_of(input vec_t v);
    case (v.mode)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return (v.xf == 3'd1) ? "R5" : "R4";
    endcase
  endfunction

  // Divisor constants by the fixed-exponent rule, bit 31 stored as zero
  task automatic mk_consts(input longint unsigned d, output vec_t v);
    int sh;
    longint unsigned num, q, r, m;
    sh = 0;
    while ((64'd1 << (sh + 1)) <= d) sh++;
    num = 64'd1 << (sh + 32);
    q = num / d;
    r = num % d;
    m = (r == 0) ? q : q + 1;
    v.mode = 2'd3;
    v.sh = 5'(sh);
    if (r <= (64'd1 << sh)) begin
      v.mult = 32'(m - 1);
      v.xf = 3'd1;
    end else begin
      v.mult = 32'(m);
      v.xf = 3'd0;
    end
    v.mult = v.mult & 32'h7FFFFFFF;
  endtask

  task automatic drive(input vec_t v);
    in_mode = v.mode; in_shift = v.sh; in_xflags = v.xf;
    in_mult = v.mult; in_index = v.idx;
  endtask

  // Streams n entries of sv/se; stall toggles out_ready; returns input-side stall count
  task automatic run_stream(input int n, input bit stall, output int in_stalls);
    int tx, rx, cyc;
    logic [31:0] held;
    bit hold_pend;
    tx = 0; rx = 0; cyc = 0; hold_pend = 0; in_stalls = 0; held = '0;
    while (rx < n && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      in_valid = (tx < n);
      if (tx < n) drive(sv[tx]);
      #1;
      if (hold_pend) begin
        chk("R7 hold valid", 32'(out_valid), 32'd1);
        chk("R7 hold data", out_index, held);
        hold_pend = 0;
      end
      if (out_valid && out_ready) begin
        chk(st[rx], out_index, se[rx]);
        rx++;
      end else if (out_valid) begin
        held = out_index;
        hold_pend = 1;
      end
      if (in_valid && in_ready) tx++;
      else if (in_valid) in_stalls++;
    end
    chk("R7 all delivered", 32'(rx), 32'(n));
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    int stalls;
    vec_t v;
    longint unsigned d;

    // R9: reset state
    repeat (3) @(negedge clk);
    #1 chk("R9 valid in reset", 32'(out_valid), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R9 valid after reset", 32'(out_valid), 32'd0);
    chk("R8 ready after reset", 32'(in_ready), 32'd1);

    // Table walk, full rate: R1..R5 and R8
    for (int i = 0; i < NTAB; i++) begin
      sv[i] = TAB[i]; se[i] = ref_out(TAB[i]); st[i] = tag_of(TAB[i]);
    end
    run_stream(NTAB, 1'b0, stalls);
    chk("R8 no input stall at full rate", 32'(stalls), 32'd0);

    // Same table under back-pressure: R7
    run_stream(NTAB, 1'b1, stalls);

    // R6: latency in an empty pipeline
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1;
    drive('{2'd0, 5'd0, 3'd0, 32'd0, 32'hCAFEF00D});
    #1 chk("R6 accepted", 32'(in_ready), 32'd1);
    @(negedge clk) in_valid = 1'b0;
    #1 chk("R6 not yet valid", 32'(out_valid), 32'd0);
    @(negedge clk);
    #1 chk("R6 valid after two edges", 32'(out_valid), 32'd1);
    chk("R1 latency data", out_index, 32'hCAFEF00D);

    // R9: reset flushes requests in flight
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    drive('{2'd0, 5'd0, 3'd0, 32'd0, 32'h11111111});
    @(negedge clk) in_valid = 1'b0;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    out_ready = 1'b1;
    #1 chk("R9 flushed", 32'(out_valid), 32'd0);
    @(negedge clk);
    #1 chk("R9 stays empty", 32'(out_valid), 32'd0);

    // R4/R5: exact division against derived constants, divisors 2..65536
    for (int i = 0; i < 200; i++) begin
      if (i == 0) d = 64'd2;
      else if (i == 1) d = 64'd65536;
      else if (i == 2) d = 64'd3;
      else d = 64'd2 + 64'($urandom % 65535);
      mk_consts(d, v);
      v.idx = (i % 7 == 0) ? 32'hFFFFFFFF : $urandom;
      sv[i] = v;
      se[i] = 32'(64'(v.idx) / d);
      st[i] = (v.xf == 3'd1) ? "R5 exact division" : "R4 exact division";
    end
    run_stream(200, 1'b1, stalls);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule